// File: doc/BRIEF.md
# Sixteen-Bit Timer/Counter with Three Compare Channels

This block is a 16-bit up-counter that sits on an 8-bit register bus. A companion prescaler supplies a one-cycle tick enable, and the counter steps once on each tick while its clock-select field is nonzero. Three compare registers and a capture/top register are checked against the count on every tick. A match sets a sticky flag. Each flag, ANDed with its mask bit, drives one of five interrupt lines. Software can select free-running operation, clear on a match with compare A, or clear on a match with the capture/top register. The block has three bus windows: the timer registers, the mask byte and the flag byte.

Sixteen-bit values pass through an 8-bit staging byte. A write to a high byte only loads the staging byte, and the later low-byte write commits both halves at once. A read of the counter's or capture register's low byte copies the matching high byte into the staging byte, so that reading the high byte afterwards returns a consistent value.

A small state machine tracks the counter. The states are STOP, RUN and BLANK. The transitions are:
- STOP goes to RUN once the clock select is nonzero.
- RUN goes to STOP when the clock select returns to zero.
- STOP or RUN goes to BLANK on a counter write.
- BLANK goes to RUN after it has consumed one tick with the clock running.
- BLANK stays in BLANK on a further counter write.

While the power-hold input is high, the whole block is held in its reset state.

Top module: `tc16_unit`

## Requirements
- R1: Bus windows are selected by `bus_sel`: 0 selects the timer registers, 1 the mask byte and 2 the flag byte. Inside the timer window the offsets are:
  - 0: control A
  - 1: control B
  - 2: control C
  - 4/5: count, low/high
  - 6/7: capture/top, low/high
  - 8/9: compare A, low/high
  - 0xA/0xB: compare B, low/high
  - 0xC/0xD: compare C, low/high

  For the count and the capture/top register, a high-byte write stages the byte and the low-byte write commits both halves. A low-byte read (with `bus_re`) latches the high byte, and the following high-byte read returns that latched byte.
- R2: The waveform mode is {control B[4:3], control A[1:0]}. In mode 0 the counter runs to 0xFFFF, then wraps to 0 and sets flag bit 0 (overflow).
- R3: The counter advances by exactly one on each cycle where `tick_en` is high and control B[2:0] is nonzero. It holds its value otherwise.
- R4: In mode 4, a tick that finds the count equal to compare A returns the count to 0 and sets flag bit 1.
- R5: In mode 12, a tick that finds the count equal to capture/top returns the count to 0 and sets flag bit 5. A compare A equality sets flag bit 1 in mode 0 and in mode 12.
- R6: A tick that finds the count equal to compare B or compare C sets flag bit 2 or bit 3 respectively, in every mode.
- R7: Mode codes other than 0, 4 and 12 count exactly as mode 0 does.
- R8: After a write to the count, the next tick increments the count but produces no compare flag and no clear-to-zero.
- R9: Writing a 1 to a flag bit clears that bit, and writing a 0 leaves it unchanged. A flag that is being set in the same cycle stays set.
- R10: Each interrupt line is its flag bit ANDed with the mask bit at the same position. A masked flag still sets and reads back.
- R11: While `pwr_hold` is high, the counter, registers, mask and flags return to 0, and all five interrupt lines are low on the following cycle.
- R12: Control B bits 7:5 and control C are stored and read back, but have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_hold | input | 1 | Power-reduction hold; synchronous reset while high |
| tick_en | input | 1 | Prescaler tick enable |
| bus_sel | input | 2 | Window select: timer, mask, flag |
| bus_addr | input | 4 | Register offset inside the timer window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for the low-byte read latch) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_capt | output | 1 | Capture/top interrupt |
| irq_cmpa | output | 1 | Compare A interrupt |
| irq_cmpb | output | 1 | Compare B interrupt |
| irq_cmpc | output | 1 | Compare C interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The bench uses the default parameters: an 8-bit bus and a 16-bit count. Because the tick enable is held high during each run, a complete 65536-tick wrap fits easily inside the run.

Four mode codes (free-running, clear on compare A, clear on capture/top, and one waveform code) are swept against top values 1 to 4 and tick counts 1 to 12. For every combination the bench works out the final count and the flag byte arithmetically from the modulus and the compare positions.

Directed cases cover:
- the overflow wrap near 0xFFFF;
- the blanked tick after a counter write;
- clearing individual flags by writing ones;
- masking;
- the power hold.

// File: rtl/tc16_pkg.sv
package tc16_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_BLANK = 2'd2
    } tc_state_e;

    localparam logic [1:0] SEL_TMR = 2'd0;
    localparam logic [1:0] SEL_MSK = 2'd1;
    localparam logic [1:0] SEL_FLG = 2'd2;

    localparam int A_CTLA  = 0;
    localparam int A_CTLB  = 1;
    localparam int A_CTLC  = 2;
    localparam int A_CNT_L = 4;
    localparam int A_CNT_H = 5;
    localparam int A_TOP_L = 6;
    localparam int A_TOP_H = 7;
    localparam int A_CPA_L = 8;
    localparam int A_CPA_H = 9;
    localparam int A_CPB_L = 10;
    localparam int A_CPB_H = 11;
    localparam int A_CPC_L = 12;
    localparam int A_CPC_H = 13;

    localparam logic [3:0] MODE_FREE  = 4'd0;
    localparam logic [3:0] MODE_CLR_A = 4'd4;
    localparam logic [3:0] MODE_CLR_I = 4'd12;

    // interrupt index: 0 overflow, 1 cmp A, 2 cmp B, 3 cmp C, 4 capture/top
    localparam int NIRQ = 5;
    localparam int IX_OVF = 0;
    localparam int IX_A   = 1;
    localparam int IX_B   = 2;
    localparam int IX_C   = 3;
    localparam int IX_CAP = 4;

    function automatic int irq_pos(input int idx);
        return (idx < 4) ? idx : 5;
    endfunction

endpackage

// File: rtl/tc16_regs.sv
module tc16_regs
    import tc16_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [1:0]        bus_sel,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [2*DW-1:0]   cnt,
    input  logic [NIRQ-1:0]   flag_q,
    output logic [3:0]        mode,
    output logic [2:0]        clk_sel,
    output logic [NIRQ-1:0]   mask_q,
    output logic [2*DW-1:0]   top_q,
    output logic [2*DW-1:0]   cpa_q,
    output logic [2*DW-1:0]   cpb_q,
    output logic [2*DW-1:0]   cpc_q,
    output logic              cnt_wr,
    output logic [2*DW-1:0]   cnt_wval,
    output logic [NIRQ-1:0]   flag_clr
);

    localparam int CW = 2 * DW;

    logic [DW-1:0]   ctla_q, ctlb_q, ctlc_q, stage_q;
    logic            win_wr, win_rd;
    logic [NIRQ-1:0] wd_pick;
    logic [DW-1:0]   mask_spread, flag_spread;

    assign win_wr = bus_we && (bus_sel == SEL_TMR) && !hold;
    assign win_rd = bus_re && (bus_sel == SEL_TMR) && !hold;

    always_comb begin
        mask_spread = '0;
        flag_spread = '0;
        for (int i = 0; i < NIRQ; i++) begin
            wd_pick[i]                = bus_wdata[irq_pos(i)];
            mask_spread[irq_pos(i)]   = mask_q[i];
            flag_spread[irq_pos(i)]   = flag_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctla_q <= '0; ctlb_q <= '0; ctlc_q <= '0; stage_q <= '0;
            top_q  <= '0; cpa_q  <= '0; cpb_q  <= '0; cpc_q   <= '0;
            mask_q <= '0;
        end else if (hold) begin
            ctla_q <= '0; ctlb_q <= '0; ctlc_q <= '0; stage_q <= '0;
            top_q  <= '0; cpa_q  <= '0; cpb_q  <= '0; cpc_q   <= '0;
            mask_q <= '0;
        end else begin
            if (bus_we && bus_sel == SEL_MSK) begin
                mask_q <= wd_pick;
            end
            if (win_rd && bus_addr == AW'(A_CNT_L)) begin
                stage_q <= cnt[CW-1:DW];
            end else if (win_rd && bus_addr == AW'(A_TOP_L)) begin
                stage_q <= top_q[CW-1:DW];
            end
            if (win_wr) begin
                case (bus_addr)
                    AW'(A_CTLA):  ctla_q <= bus_wdata;
                    AW'(A_CTLB):  ctlb_q <= bus_wdata;
                    AW'(A_CTLC):  ctlc_q <= bus_wdata;
                    AW'(A_CNT_H): stage_q <= bus_wdata;
                    AW'(A_TOP_H): stage_q <= bus_wdata;
                    AW'(A_TOP_L): top_q <= {stage_q, bus_wdata};
                    AW'(A_CPA_L): cpa_q[DW-1:0]  <= bus_wdata;
                    AW'(A_CPA_H): cpa_q[CW-1:DW] <= bus_wdata;
                    AW'(A_CPB_L): cpb_q[DW-1:0]  <= bus_wdata;
                    AW'(A_CPB_H): cpb_q[CW-1:DW] <= bus_wdata;
                    AW'(A_CPC_L): cpc_q[DW-1:0]  <= bus_wdata;
                    AW'(A_CPC_H): cpc_q[CW-1:DW] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    assign mode     = {ctlb_q[4:3], ctla_q[1:0]};
    assign clk_sel  = ctlb_q[2:0];
    assign cnt_wr   = win_wr && (bus_addr == AW'(A_CNT_L));
    assign cnt_wval = {stage_q, bus_wdata};
    assign flag_clr = (bus_we && bus_sel == SEL_FLG && !hold) ? wd_pick : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_MSK: bus_rdata = mask_spread;
            SEL_FLG: bus_rdata = flag_spread;
            SEL_TMR: begin
                case (bus_addr)
                    AW'(A_CTLA):  bus_rdata = ctla_q;
                    AW'(A_CTLB):  bus_rdata = ctlb_q;
                    AW'(A_CTLC):  bus_rdata = ctlc_q;
                    AW'(A_CNT_L): bus_rdata = cnt[DW-1:0];
                    AW'(A_CNT_H): bus_rdata = stage_q;
                    AW'(A_TOP_L): bus_rdata = top_q[DW-1:0];
                    AW'(A_TOP_H): bus_rdata = stage_q;
                    AW'(A_CPA_L): bus_rdata = cpa_q[DW-1:0];
                    AW'(A_CPA_H): bus_rdata = cpa_q[CW-1:DW];
                    AW'(A_CPB_L): bus_rdata = cpb_q[DW-1:0];
                    AW'(A_CPB_H): bus_rdata = cpb_q[CW-1:DW];
                    AW'(A_CPC_L): bus_rdata = cpc_q[DW-1:0];
                    AW'(A_CPC_H): bus_rdata = cpc_q[CW-1:DW];
                    default:      bus_rdata = '0;
                endcase
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tc16_core.sv
module tc16_core
    import tc16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [2:0]       clk_sel,
    input  logic [3:0]       mode,
    input  logic [2*DW-1:0]  top,
    input  logic [2*DW-1:0]  cpa,
    input  logic [2*DW-1:0]  cpb,
    input  logic [2*DW-1:0]  cpc,
    input  logic             cnt_wr,
    input  logic [2*DW-1:0]  cnt_wval,
    output logic [2*DW-1:0]  cnt_q,
    output logic [NIRQ-1:0]  ev
);

    localparam int          CW   = 2 * DW;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    tc_state_e     state_q, state_d;
    logic          cs_on, adv, live, clr_top;
    logic [CW-1:0] cnt_d;

    assign cs_on = (clk_sel != 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
        end else if (hold) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (cnt_wr) state_d = ST_BLANK;
                      else if (cs_on) state_d = ST_RUN;
            ST_RUN:   if (cnt_wr) state_d = ST_BLANK;
                      else if (!cs_on) state_d = ST_STOP;
            ST_BLANK: if (cnt_wr) state_d = ST_BLANK;
                      else if (tick && cs_on) state_d = ST_RUN;
            default:  state_d = ST_STOP;
        endcase
    end

    always_comb begin
        adv     = tick && cs_on && (state_q != ST_STOP) && !cnt_wr;
        live    = adv && (state_q == ST_RUN);
        clr_top = live && (((mode == MODE_CLR_A) && (cnt_q == cpa)) ||
                           ((mode == MODE_CLR_I) && (cnt_q == top)));
        ev          = '0;
        ev[IX_A]    = live && (cnt_q == cpa);
        ev[IX_B]    = live && (cnt_q == cpb);
        ev[IX_C]    = live && (cnt_q == cpc);
        ev[IX_CAP]  = live && (mode == MODE_CLR_I) && (cnt_q == top);
        ev[IX_OVF]  = adv && !clr_top && (cnt_q == CMAX);
        if (cnt_wr)       cnt_d = cnt_wval;
        else if (clr_top) cnt_d = '0;
        else if (adv)     cnt_d = cnt_q + 1'b1;
        else              cnt_d = cnt_q;
    end

    a_r3_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr && !hold) |=> $stable(cnt_q));

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cs_on && state_q != ST_STOP && !cnt_wr && !hold &&
         mode == MODE_FREE && cnt_q == CMAX) |=> (cnt_q == '0));

    a_r4_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cs_on && state_q == ST_RUN && !cnt_wr && !hold &&
         mode == MODE_CLR_A && cnt_q == cpa) |=> (cnt_q == '0));

    a_r8_blank_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cs_on && state_q == ST_BLANK && !cnt_wr && !hold)
        |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/tc16_flags.sv
module tc16_flags
    import tc16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [NIRQ-1:0] ev,
    input  logic [NIRQ-1:0] clr,
    input  logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] flag_q,
    output logic [NIRQ-1:0] irq
);

    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag_q[i] <= 1'b0;
            else if (hold)   flag_q[i] <= 1'b0;
            else if (ev[i])  flag_q[i] <= 1'b1;
            else if (clr[i]) flag_q[i] <= 1'b0;
        end

        assign irq[i] = flag_q[i] & mask[i];

        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ev[i]) |=> !flag_q[i]);

        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && !hold) |=> flag_q[i]);
    end

endmodule

// File: rtl/tc16_unit.sv
module tc16_unit
    import tc16_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_hold,
    input  logic          tick_en,
    input  logic [1:0]    bus_sel,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_capt,
    output logic          irq_cmpa,
    output logic          irq_cmpb,
    output logic          irq_cmpc,
    output logic          irq_ovf
);

    localparam int CW = 2 * DW;

    logic [3:0]      mode;
    logic [2:0]      clk_sel;
    logic [NIRQ-1:0] mask_q, flag_q, flag_clr, ev, irq;
    logic [CW-1:0]   top_q, cpa_q, cpb_q, cpc_q, cnt_q, cnt_wval;
    logic            cnt_wr;

    tc16_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hold(pwr_hold),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt_q), .flag_q(flag_q), .mode(mode), .clk_sel(clk_sel),
        .mask_q(mask_q), .top_q(top_q), .cpa_q(cpa_q), .cpb_q(cpb_q),
        .cpc_q(cpc_q), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
        .flag_clr(flag_clr)
    );

    tc16_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .hold(pwr_hold), .tick(tick_en),
        .clk_sel(clk_sel), .mode(mode), .top(top_q), .cpa(cpa_q),
        .cpb(cpb_q), .cpc(cpc_q), .cnt_wr(cnt_wr), .cnt_wval(cnt_wval),
        .cnt_q(cnt_q), .ev(ev)
    );

    tc16_flags u_flags (
        .clk(clk), .rst_n(rst_n), .hold(pwr_hold), .ev(ev),
        .clr(flag_clr), .mask(mask_q), .flag_q(flag_q), .irq(irq)
    );

    assign irq_ovf  = irq[IX_OVF];
    assign irq_cmpa = irq[IX_A];
    assign irq_cmpb = irq[IX_B];
    assign irq_cmpc = irq[IX_C];
    assign irq_capt = irq[IX_CAP];

    a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_hold |=> !(irq_ovf || irq_cmpa || irq_cmpb || irq_cmpc || irq_capt));

endmodule

// File: tb/test_tc16_unit.sv
module test_tc16_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_hold = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_capt, irq_cmpa, irq_cmpb, irq_cmpc, irq_ovf;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tc16_unit i_tc16_unit (
        .clk(clk), .rst_n(rst_n), .pwr_hold(pwr_hold), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_capt(irq_capt), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb),
        .irq_cmpc(irq_cmpc), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] lo, hi;
        rd(2'd0, 4'd4, lo);
        rd(2'd0, 4'd5, hi);
        c = {hi, lo};
    endtask

    task automatic wr_cnt(input logic [15:0] c);
        wr(2'd0, 4'd5, c[15:8]);
        wr(2'd0, 4'd4, c[7:0]);
    endtask

    task automatic wr16(input logic [3:0] lo_addr, input logic [15:0] v);
        wr(2'd0, lo_addr + 4'd1, v[15:8]);
        wr(2'd0, lo_addr, v[7:0]);
    endtask

    task automatic set_mode(input logic [3:0] m, input logic [2:0] cs);
        wr(2'd0, 4'd0, {6'd0, m[1:0]});
        wr(2'd0, 4'd1, {3'd0, m[3:2], cs});
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    function automatic logic [4:0] irq_vec();
        return {irq_capt, irq_cmpc, irq_cmpb, irq_cmpa, irq_ovf};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R11)
        rd_cnt(c);
        chk("R11 reset count", c, 16'h0);
        #1 chk("R11 reset irqs", irq_vec(), 5'h0);
        rd(2'd2, 4'd0, v);
        chk("R11 reset flags", v, 8'h0);

        wr(2'd1, 4'd0, 8'h2F);
        rd(2'd1, 4'd0, v);
        chk("R10 mask readback", v, 8'h2F);

        // R3: count only on tick with clock select nonzero
        set_mode(4'd0, 3'd1);
        repeat (3) @(negedge clk);
        rd_cnt(c);
        chk("R3 no tick no count", c, 16'h0);
        ticks(7);
        rd_cnt(c);
        chk("R3 seven ticks", c, 16'd7);
        set_mode(4'd0, 3'd0);
        ticks(3);
        rd_cnt(c);
        chk("R3 stopped clock select", c, 16'd7);

        // R1: staged 16-bit access
        wr_cnt(16'h1234);
        rd_cnt(c);
        chk("R1 count write/read", c, 16'h1234);
        wr16(4'd6, 16'hA55A);
        rd(2'd0, 4'd6, v);
        chk("R1 top low", v, 8'h5A);
        rd(2'd0, 4'd7, v);
        chk("R1 top high via stage", v, 8'hA5);
        wr16(4'd10, 16'hBEEF);
        rd(2'd0, 4'd11, v);
        chk("R1 compare B high", v, 8'hBE);

        // R12: stored but inert bits
        wr(2'd0, 4'd1, 8'hE1);
        wr(2'd0, 4'd2, 8'hA5);
        rd(2'd0, 4'd1, v);
        chk("R12 control B readback", v, 8'hE1);
        rd(2'd0, 4'd2, v);
        chk("R12 control C readback", v, 8'hA5);
        wr16(4'd10, 16'h0);
        wr_cnt(16'h0100);
        repeat (2) @(negedge clk);
        ticks(3);
        rd_cnt(c);
        chk("R12 counting unaffected", c, 16'h0103);

        // sweep over modes, tops and tick counts (R4 R5 R6 R7 R10)
        for (int mi = 0; mi < 4; mi++) begin
            logic [3:0] m;
            m = (mi == 0) ? 4'd0 : (mi == 1) ? 4'd4 : (mi == 2) ? 4'd12 : 4'd5;
            for (int t = 1; t <= 4; t++) begin
                int ca, top;
                ca  = (m == 4'd12) ? 1 : t;
                top = (m == 4'd4) ? ca : (m == 4'd12) ? t : 0;
                set_mode(m, 3'd1);
                wr16(4'd8, 16'(ca));
                wr16(4'd10, 16'd2);
                wr16(4'd12, 16'd3);
                wr16(4'd6, 16'(t));
                for (int n = 1; n <= 12; n++) begin
                    int ce;
                    logic fa, fb, fc, fi;
                    logic [7:0] fe;
                    wr_cnt(16'h0);
                    wr(2'd2, 4'd0, 8'hFF);
                    ticks(n);
                    ce = (top != 0) ? n % (top + 1) : n;
                    fa = (n > ca) && (top == 0 || ca <= top);
                    fb = (n > 2) && (top == 0 || 2 <= top);
                    fc = (n > 3) && (top == 0 || 3 <= top);
                    fi = (m == 4'd12) && (n > t);
                    fe = {2'b0, fi, 1'b0, fc, fb, fa, 1'b0};
                    rd_cnt(c);
                    chk(m == 4'd4 ? "R4 count" : m == 4'd12 ? "R5 count" :
                        m == 4'd5 ? "R7 count" : "R6 count", c, 32'(ce));
                    rd(2'd2, 4'd0, v);
                    chk(m == 4'd4 ? "R4 flags" : m == 4'd12 ? "R5 flags" :
                        m == 4'd5 ? "R7 flags" : "R6 flags", v, fe);
                    #1 chk("R10 irq lines", irq_vec(), {fi, fc, fb, fa, 1'b0});
                end
            end
        end

        // R8: blanked tick after counter write
        set_mode(4'd0, 3'd1);
        wr16(4'd10, 16'd0);
        wr_cnt(16'h0);
        wr(2'd2, 4'd0, 8'hFF);
        ticks(1);
        rd(2'd2, 4'd0, v);
        chk("R8 compare B blanked", v & 8'h04, 8'h00);
        rd_cnt(c);
        chk("R8 blank tick still counts", c, 16'd1);
        set_mode(4'd4, 3'd1);
        wr16(4'd8, 16'd5);
        wr_cnt(16'd5);
        wr(2'd2, 4'd0, 8'hFF);
        ticks(1);
        rd_cnt(c);
        chk("R8 top clear blanked", c, 16'd6);
        rd(2'd2, 4'd0, v);
        chk("R8 compare A blanked", v & 8'h02, 8'h00);

        // R2: overflow wrap
        set_mode(4'd0, 3'd1);
        wr16(4'd8, 16'h8000);
        wr16(4'd10, 16'h8000);
        wr16(4'd12, 16'h8000);
        wr_cnt(16'hFFFD);
        wr(2'd2, 4'd0, 8'hFF);
        ticks(5);
        rd_cnt(c);
        chk("R2 wrap count", c, 16'd2);
        rd(2'd2, 4'd0, v);
        chk("R2 overflow flag", v & 8'h01, 8'h01);
        #1 chk("R10 overflow irq", irq_ovf, 1'b1);
        wr_cnt(16'h0);
        wr(2'd2, 4'd0, 8'hFF);
        ticks(65536);
        rd_cnt(c);
        chk("R2 full period", c, 16'h0);
        rd(2'd2, 4'd0, v);
        chk("R2 full period overflow", v & 8'h01, 8'h01);

        // R7: waveform code counts as free-running
        set_mode(4'd14, 3'd1);
        wr_cnt(16'hFFFE);
        wr(2'd2, 4'd0, 8'hFF);
        ticks(3);
        rd_cnt(c);
        chk("R7 mode 14 wraps", c, 16'd1);
        rd(2'd2, 4'd0, v);
        chk("R7 mode 14 overflow", v & 8'h01, 8'h01);

        // R9: write-one-to-clear of a single bit
        set_mode(4'd0, 3'd1);
        wr16(4'd8, 16'd2);
        wr16(4'd10, 16'd3);
        wr_cnt(16'h0);
        wr(2'd2, 4'd0, 8'hFF);
        ticks(5);
        rd(2'd2, 4'd0, v);
        chk("R9 both set", v, 8'h06);
        wr(2'd2, 4'd0, 8'h02);
        rd(2'd2, 4'd0, v);
        chk("R9 clear only A", v, 8'h04);
        wr(2'd2, 4'd0, 8'h00);
        rd(2'd2, 4'd0, v);
        chk("R9 zero write keeps", v, 8'h04);

        // R10: masked flag sets, line stays low
        wr(2'd1, 4'd0, 8'h00);
        #1 chk("R10 masked irq low", irq_cmpb, 1'b0);
        rd(2'd2, 4'd0, v);
        chk("R10 masked flag kept", v, 8'h04);
        wr(2'd1, 4'd0, 8'h04);
        #1 chk("R10 unmask irq", irq_cmpb, 1'b1);

        // R11: power hold
        @(negedge clk);
        pwr_hold = 1'b1;
        @(negedge clk);
        pwr_hold = 1'b0;
        #1 chk("R11 irqs low", irq_vec(), 5'h0);
        rd_cnt(c);
        chk("R11 count cleared", c, 16'h0);
        rd(2'd0, 4'd1, v);
        chk("R11 control cleared", v, 8'h00);
        rd(2'd1, 4'd0, v);
        chk("R11 mask cleared", v, 8'h00);
        rd(2'd2, 4'd0, v);
        chk("R11 flags cleared", v, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule